// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block sits between the serial control register of a triple half-bridge driver and its gate drivers. It holds the six switch requests delivered by a commit strobe. It gates them with the protection state and drives six switch enables. It also assembles the 16-bit status word that the serial interface shifts back. The inputs are raw comparator flags: per-switch overcurrent, per-switch low current, supply undervoltage, thermal prewarning and thermal shutdown. Each fault class follows its own rules for latching and recovery.

Undervoltage, overcurrent and open-load conditions must persist for a programmable number of system clock cycles before they count. Any break in a condition restarts its count. Thermal shutdown acts on the first sampled cycle. Undervoltage lifts its output block by itself, but its flag stays set. Thermal and short-circuit shutdowns are released only by a status reset written with a commit. A short seen while shutdown is disarmed only raises the flag. Pulling the inhibit input low clears everything, which gives a fresh power-on state when it is raised again.

Top module: `hb_fault_supervisor`

## Requirements
- R1: After reset, all six switch enables are 0 and every status bit except bit 0 is 0.
- R2: A commit loads the six requests (index 0..5 = LS1, HS1, LS2, HS2, LS3, HS3) and the overcurrent-shutdown arm bit, and the enables follow from the next cycle. Status bits 1..6 report the applied enables in the same order.
- R3: Undervoltage held for UV_DLY consecutive clock edges forces all enables to 0 until it clears.
- R4: A qualified undervoltage sets status bit 15 one cycle later. When the undervoltage drops, the enables return one cycle later, and bit 15 stays set until a status reset.
- R5: An applied switch whose low-current flag is held for OL_DLY edges sets status bit 14, which stays set until a status reset.
- R6: Status bit 0 follows the prewarning input combinationally with no latching.
- R7: Thermal shutdown turns all enables off from the next cycle. A status reset frees them only when it is committed while the shutdown input is low. A status reset committed while that input is high has no effect.
- R8: With shutdown armed, an overcurrent on an applied switch held for OC_DLY edges turns off only that switch from the next cycle and sets status bit 13.
- R9: With shutdown disarmed, a qualified overcurrent sets status bit 13 and changes no enable.
- R10: A commit with status reset clears bits 13..15 and releases switches turned off by a short, and it leaves the requests as committed. A fault qualifying in the same cycle wins over the clear.
- R11: With inhibit low, all enables and the whole status word are 0 at once. When inhibit is raised, requests and flags start from the reset state.
- R12: A qualification count restarts when its raw condition drops before the count completes, so UV_DLY-1 edges of undervoltage have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_n | input | 1 | Low = standby: everything off and cleared |
| commit | input | 1 | Strobe that applies req_sw, ocs_en and sts_rst |
| req_sw | input | 6 | Requested switch states, LS1..HS3 |
| ocs_en | input | 1 | Arms overcurrent shutdown |
| sts_rst | input | 1 | Status reset request, acted on with commit |
| oc_raw | input | 6 | Per-switch overcurrent comparator |
| lowi_raw | input | 6 | Per-switch low-current comparator |
| uv_raw | input | 1 | Supply undervoltage comparator |
| tpw_raw | input | 1 | Thermal prewarning comparator |
| tsd_raw | input | 1 | Thermal shutdown comparator |
| sw_en | output | 6 | Gated switch enables, LS1..HS3 |
| status_word | output | 16 | Bit 0 prewarning, 1..6 applied enables, 13 short, 14 open load, 15 supply fail |

## Verification
The bench builds the block with UV_DLY=4, OC_DLY=3 and OL_DLY=6. These short windows let directed sequences hit each edge of a qualification count: one edge short of the limit, exactly at it, and one past it. Random stimulus can then complete many qualifications and restarts. Fault conditions collide often with status resets, commits and inhibit pulses in these runs, so the set-wins-over-clear ordering and the recovery rules are exercised repeatedly.

// File: rtl/hbfs_pkg.sv
package hbfs_pkg;
  localparam int unsigned SW_N     = 6;
  localparam int unsigned STATUS_W = 16;
  localparam int unsigned TP_BIT   = 0;
  localparam int unsigned SW_LSB   = 1;
  localparam int unsigned SCD_BIT  = 13;
  localparam int unsigned OPL_BIT  = 14;
  localparam int unsigned PSF_BIT  = 15;

  // Assemble the status word from its fields.
  function automatic logic [STATUS_W-1:0] pack_status(
    input logic            tp,
    input logic [SW_N-1:0] en,
    input logic            scd,
    input logic            opl,
    input logic            psf
  );
    logic [STATUS_W-1:0] w;
    w = '0;
    w[TP_BIT] = tp;
    w[SW_LSB +: SW_N] = en;
    w[SCD_BIT] = scd;
    w[OPL_BIT] = opl;
    w[PSF_BIT] = psf;
    return w;
  endfunction

  // Sticky flag update: a new set wins over a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr_req);
    if (set) return 1'b1;
    if (clr_req) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/hbfs_qual.sv
module hbfs_qual #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic raw,
  output logic hit
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] count_next(input logic [CW-1:0] c, input logic r);
    if (!r) return '0;
    if (c == LIM) return c;
    return CW'(c + 1'b1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= count_next(cnt_q, raw);
  end

  assign hit = (cnt_q == LIM);

  assert_hit_needs_raw_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(raw));
  assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw && !clr) |=> !hit);
endmodule

// File: rtl/hbfs_slice.sv
module hbfs_slice #(
  parameter int unsigned OC_DLY = 4,
  parameter int unsigned OL_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  input  logic block,
  input  logic ocs,
  input  logic srst,
  input  logic oc_raw,
  input  logic lowi_raw,
  output logic en,
  output logic oc_hit,
  output logic ol_hit
);
  logic short_q;
  logic oc_seen;
  logic ol_seen;

  assign en      = req & ~short_q & ~block;
  assign oc_seen = oc_raw & en;
  assign ol_seen = lowi_raw & en;

  hbfs_qual #(.LEN(OC_DLY)) u_oc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .raw(oc_seen), .hit(oc_hit));

  hbfs_qual #(.LEN(OL_DLY)) u_ol (
    .clk(clk), .rst_n(rst_n), .clr(clr), .raw(ol_seen), .hit(ol_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   short_q <= 1'b0;
    else if (clr) short_q <= 1'b0;
    else          short_q <= hbfs_pkg::sticky_next(short_q, oc_hit & ocs, srst);
  end

  assert_short_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_hit && ocs && !clr) |=> !en);
  assert_block_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> !en);
endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor #(
  parameter int unsigned UV_DLY = 400,
  parameter int unsigned OC_DLY = 400,
  parameter int unsigned OL_DLY = 4000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            inhibit_n,
  input  logic                            commit,
  input  logic [hbfs_pkg::SW_N-1:0]       req_sw,
  input  logic                            ocs_en,
  input  logic                            sts_rst,
  input  logic [hbfs_pkg::SW_N-1:0]       oc_raw,
  input  logic [hbfs_pkg::SW_N-1:0]       lowi_raw,
  input  logic                            uv_raw,
  input  logic                            tpw_raw,
  input  logic                            tsd_raw,
  output logic [hbfs_pkg::SW_N-1:0]       sw_en,
  output logic [hbfs_pkg::STATUS_W-1:0]   status_word
);
  localparam int unsigned N = hbfs_pkg::SW_N;

  logic         clr;
  logic         srst;
  logic         block;
  logic         uv_hit;
  logic         tsd_q;
  logic         ocs_q;
  logic         psf_q, opl_q, scd_q;
  logic [N-1:0] req_q;
  logic [N-1:0] oc_hit;
  logic [N-1:0] ol_hit;

  assign clr   = ~inhibit_n;
  assign srst  = commit & sts_rst;
  assign block = clr | uv_hit | tsd_q;

  hbfs_qual #(.LEN(UV_DLY)) u_uv (
    .clk(clk), .rst_n(rst_n), .clr(clr), .raw(uv_raw), .hit(uv_hit));

  for (genvar i = 0; i < N; i++) begin : g_sw
    hbfs_slice #(.OC_DLY(OC_DLY), .OL_DLY(OL_DLY)) u_slice (
      .clk(clk), .rst_n(rst_n), .clr(clr), .req(req_q[i]), .block(block),
      .ocs(ocs_q), .srst(srst), .oc_raw(oc_raw[i]), .lowi_raw(lowi_raw[i]),
      .en(sw_en[i]), .oc_hit(oc_hit[i]), .ol_hit(ol_hit[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      ocs_q <= 1'b1;
      tsd_q <= 1'b0;
      psf_q <= 1'b0;
      opl_q <= 1'b0;
      scd_q <= 1'b0;
    end else if (clr) begin
      req_q <= '0;
      ocs_q <= 1'b1;
      tsd_q <= 1'b0;
      psf_q <= 1'b0;
      opl_q <= 1'b0;
      scd_q <= 1'b0;
    end else begin
      if (commit) begin
        req_q <= req_sw;
        ocs_q <= ocs_en;
      end
      tsd_q <= hbfs_pkg::sticky_next(tsd_q, tsd_raw, srst);
      psf_q <= hbfs_pkg::sticky_next(psf_q, uv_hit, srst);
      opl_q <= hbfs_pkg::sticky_next(opl_q, |ol_hit, srst);
      scd_q <= hbfs_pkg::sticky_next(scd_q, |oc_hit, srst);
    end
  end

  assign status_word = hbfs_pkg::pack_status(tpw_raw & inhibit_n, sw_en,
                                             scd_q & inhibit_n,
                                             opl_q & inhibit_n,
                                             psf_q & inhibit_n);

  assert_psf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[hbfs_pkg::PSF_BIT] && !srst) |=> (status_word[hbfs_pkg::PSF_BIT] || !inhibit_n));
  assert_thermal_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_raw && inhibit_n) |=> (sw_en == '0));
  assert_inhibit_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |-> (sw_en == '0 && status_word == '0));
  assert_flag_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ocs_q && (|oc_hit) && inhibit_n) |=> (status_word[hbfs_pkg::SCD_BIT] || !inhibit_n));
endmodule

// File: tb/tb_hb_fault_supervisor.sv
module tb_hb_fault_supervisor;
  localparam int UVD = 4;
  localparam int OCD = 3;
  localparam int OLD = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, inhibit_n, commit, ocs_en, sts_rst, uv_raw, tpw_raw, tsd_raw;
  logic [5:0]  req_sw, oc_raw, lowi_raw, sw_en;
  logic [15:0] status_word;

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";

  hb_fault_supervisor #(.UV_DLY(UVD), .OC_DLY(OCD), .OL_DLY(OLD)) dut (
    .clk(clk), .rst_n(rst_n), .inhibit_n(inhibit_n), .commit(commit),
    .req_sw(req_sw), .ocs_en(ocs_en), .sts_rst(sts_rst), .oc_raw(oc_raw),
    .lowi_raw(lowi_raw), .uv_raw(uv_raw), .tpw_raw(tpw_raw), .tsd_raw(tsd_raw),
    .sw_en(sw_en), .status_word(status_word));

  // Reference model state
  logic [5:0] m_req, m_short;
  logic       m_ocs, m_psf, m_opl, m_scd, m_tsd;
  int         m_uv;
  int         m_oc [6];
  int         m_ol [6];

  function automatic int bump(input int c, input logic r, input int lim);
    if (!r) return 0;
    return (c >= lim) ? lim : c + 1;
  endfunction

  function automatic logic [5:0] exp_en();
    if (!inhibit_n) return 6'b0;
    if (m_uv == UVD || m_tsd) return 6'b0;
    return m_req & ~m_short;
  endfunction

  function automatic logic [15:0] exp_status();
    if (!inhibit_n) return 16'h0;
    return {m_psf, m_opl, m_scd, 6'b0, exp_en(), tpw_raw};
  endfunction

  task automatic model_reset();
    m_req = '0; m_short = '0; m_ocs = 1'b1;
    m_psf = 0; m_opl = 0; m_scd = 0; m_tsd = 0; m_uv = 0;
    for (int i = 0; i < 6; i++) begin m_oc[i] = 0; m_ol[i] = 0; end
  endtask

  task automatic model_step();
    logic [5:0] en;
    logic       any_oc, any_ol, uvh, rs;
    if (!inhibit_n) begin
      model_reset();
      return;
    end
    en = exp_en();
    rs = commit & sts_rst;
    uvh = (m_uv == UVD);
    any_oc = 0; any_ol = 0;
    for (int i = 0; i < 6; i++) begin
      if (m_oc[i] == OCD) begin
        any_oc = 1;
        if (m_ocs) m_short[i] = 1'b1;
      end else if (rs) m_short[i] = 1'b0;
      if (m_ol[i] == OLD) any_ol = 1;
      m_oc[i] = bump(m_oc[i], oc_raw[i] & en[i], OCD);
      m_ol[i] = bump(m_ol[i], lowi_raw[i] & en[i], OLD);
    end
    m_psf = uvh    ? 1'b1 : (rs ? 1'b0 : m_psf);
    m_scd = any_oc ? 1'b1 : (rs ? 1'b0 : m_scd);
    m_opl = any_ol ? 1'b1 : (rs ? 1'b0 : m_opl);
    m_tsd = tsd_raw ? 1'b1 : (rs ? 1'b0 : m_tsd);
    m_uv  = bump(m_uv, uv_raw, UVD);
    if (commit) begin
      m_req = req_sw;
      m_ocs = ocs_en;
    end
  endtask

  task automatic chk(input string t, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, got, exp);
    end
  endtask

  // One cycle: compare at negedge+1, advance the model, wait for next negedge.
  task automatic cyc();
    #1;
    chk(tag, {10'b0, sw_en}, {10'b0, exp_en()});
    chk(tag, status_word, exp_status());
    model_step();
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic do_commit(input logic [5:0] r, input logic o, input logic s);
    req_sw = r; ocs_en = o; sts_rst = s; commit = 1'b1;
    cyc();
    commit = 1'b0; sts_rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    rst_n = 0; inhibit_n = 1; commit = 0; req_sw = 0; ocs_en = 1; sts_rst = 0;
    oc_raw = 0; lowi_raw = 0; uv_raw = 0; tpw_raw = 0; tsd_raw = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    tag = "R1";
    run(2);
    chk("R1 enables", {10'b0, sw_en}, 16'h0);
    chk("R1 status", status_word, 16'h0);

    tag = "R2";
    do_commit(6'b010101, 1'b1, 1'b0);
    run(1);
    chk("R2 enables", {10'b0, sw_en}, 16'h0015);
    chk("R2 status", status_word, 16'h002A);

    tag = "R12";
    uv_raw = 1; run(UVD - 1);
    uv_raw = 0; run(2);
    chk("R12 no trip", {10'b0, sw_en}, 16'h0015);
    chk("R12 no flag", {15'b0, status_word[15]}, 16'h0);

    tag = "R3";
    uv_raw = 1; run(UVD);
    chk("R3 all off", {10'b0, sw_en}, 16'h0);
    run(1);
    tag = "R4";
    chk("R4 flag", {15'b0, status_word[15]}, 16'h1);
    uv_raw = 0; run(1);
    chk("R4 return", {10'b0, sw_en}, 16'h0015);
    chk("R4 stays", {15'b0, status_word[15]}, 16'h1);
    do_commit(6'b010101, 1'b1, 1'b1);
    chk("R4 cleared", {15'b0, status_word[15]}, 16'h0);

    tag = "R5";
    lowi_raw = 6'b000001; run(OLD + 1);
    chk("R5 open load", {15'b0, status_word[14]}, 16'h1);
    lowi_raw = 0; run(2);
    chk("R5 stays", {15'b0, status_word[14]}, 16'h1);
    do_commit(6'b010101, 1'b1, 1'b1);

    tag = "R6";
    tpw_raw = 1; #1;
    chk("R6 prewarn on", {15'b0, status_word[0]}, 16'h1);
    run(1);
    tpw_raw = 0; #1;
    chk("R6 prewarn off", {15'b0, status_word[0]}, 16'h0);
    run(1);

    tag = "R7";
    tsd_raw = 1; run(1);
    chk("R7 off", {10'b0, sw_en}, 16'h0);
    do_commit(6'b010101, 1'b1, 1'b1);
    run(1);
    chk("R7 reset ignored while hot", {10'b0, sw_en}, 16'h0);
    tsd_raw = 0; run(3);
    chk("R7 held off", {10'b0, sw_en}, 16'h0);
    do_commit(6'b010101, 1'b1, 1'b1);
    chk("R7 released", {10'b0, sw_en}, 16'h0015);

    tag = "R8";
    oc_raw = 6'b000100; run(OCD + 1);
    chk("R8 one switch off", {10'b0, sw_en}, 16'h0011);
    chk("R8 short flag", {15'b0, status_word[13]}, 16'h1);
    oc_raw = 0; run(2);

    tag = "R10";
    do_commit(6'b010101, 1'b1, 1'b1);
    chk("R10 restored", {10'b0, sw_en}, 16'h0015);
    chk("R10 flags clear", {13'b0, status_word[15:13]}, 16'h0);

    tag = "R9";
    do_commit(6'b010101, 1'b0, 1'b0);
    oc_raw = 6'b010000; run(OCD + 2);
    chk("R9 no shutdown", {10'b0, sw_en}, 16'h0015);
    chk("R9 short flag", {15'b0, status_word[13]}, 16'h1);
    oc_raw = 0;
    do_commit(6'b010101, 1'b1, 1'b1);

    tag = "R11";
    inhibit_n = 0; #1;
    chk("R11 inhibit enables", {10'b0, sw_en}, 16'h0);
    chk("R11 inhibit status", status_word, 16'h0);
    run(2);
    inhibit_n = 1; run(1);
    chk("R11 fresh start", {10'b0, sw_en}, 16'h0);

    tag = "R10";
    for (int n = 0; n < 5000; n++) begin
      commit = 0; sts_rst = 0;
      if ($urandom_range(15) == 0) begin
        commit = 1; req_sw = 6'($urandom); ocs_en = 1'($urandom);
        sts_rst = ($urandom_range(2) == 0);
      end
      if ($urandom_range(39) == 0)  uv_raw  = ~uv_raw;
      if ($urandom_range(79) == 0)  tsd_raw = ~tsd_raw;
      if ($urandom_range(9) == 0)   tpw_raw = ~tpw_raw;
      if ($urandom_range(199) == 0) inhibit_n = ~inhibit_n;
      for (int i = 0; i < 6; i++) begin
        if ($urandom_range(11) == 0) oc_raw[i]   = ~oc_raw[i];
        if ($urandom_range(9) == 0)  lowi_raw[i] = ~lowi_raw[i];
      end
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule